// File: doc/BRIEF.md
# Buffered Memory-to-Memory DMA Engine

This block moves a programmed number of bytes from a source address to a destination address on its own. It has a single channel. Software-side logic sets up a size code, the two start addresses, the two increment bits and a byte count. It then pulses `start`. The engine copies the settings into working counters and alternates between two phases. In the first it reads a chunk of up to `BUF_DEPTH` beats into a local 64-bit-wide buffer. In the second it writes that chunk back out. It repeats until the count is used up. Reads and writes are never in flight at the same time.

Either side can be held on one address. This serves devices that behave as a FIFO at a fixed location. The other choice is to step by the beat size after every beat. The beat is 4 or 8 bytes. A byte count that is not a whole number of beats is rounded up when reading. The final write then enables only the bytes that are still owed. If a slave cuts a burst short, the engine re-requests the rest of the chunk. If a slave reports an error, the engine stops on the spot. The live address and length outputs then show how far it got.

The bus port is a plain master port. The request stays high for one transaction. Address, direction and burst flag are valid with it. A beat completes in each cycle where the slave returns `bus_ack`. `bus_term` with an ack ends the transaction at that beat. `bus_err` aborts it.

Top module: `dma_mover`

## Requirements
- R1: A `start` pulse seen while idle copies the settings into the working registers and makes `busy` high on the next cycle. A `start` while `busy` is high changes nothing.
- R2: A size code of 4'b0100 selects 4-byte beats. Any other code selects 8-byte beats. Each beat moves one beat, and an incrementing address steps by exactly the beat size.
- R3: With its increment bit at 1, a side's address (`bus_addr` and the matching `cur_src`/`cur_dst`) advances by the beat size after each completed beat of that side. With the bit at 0 it stays at the programmed value.
- R4: Each chunk has min(`BUF_DEPTH`, beats still owed) beats. All of a chunk is read before any of it is written, and every written beat carries the data read for the same beat position.
- R5: During a transaction `bus_burst` is 1 while at least two beats of the current chunk remain on that side, and 0 on a single remaining beat. A 264-byte move with 8-byte beats takes read transactions of 16, 16 and 1 beats.
- R6: Reads enable all bytes of the beat. On a write, `bus_be` enables only the bytes still owed, counted upward from the lowest byte of the beat.
- R7: After a transaction ends early through `bus_term`, the engine re-requests from the next beat of the chunk, at the next address, with the next buffered data.
- R8: `bus_err` during a transaction ends the operation in the next cycle. `busy` falls, `err_flag` rises and stays up until the next accepted `start`, and no `done` pulse is given. `cur_src` reflects the completed read beats and `cur_len` the completed write beats.
- R9: After reset `busy`, `done`, `err_flag` and `bus_req` are 0. On normal completion `busy` falls in the same cycle that `done` pulses for one cycle. A zero byte count completes with no bus transaction.
- R10: `cur_len` equals the bytes still to be written. It drops by the beat size on each completed write beat, does not go below zero, and changes at no other time while busy.
- R11: For 4-byte beats on the 64-bit path, address bit 2 = 1 selects data bits 63:32 and byte enables 7:4, and bit 2 = 0 selects bits 31:0 and enables 3:0. This applies both to taking read data and to driving write data, with the unused half driven to zero.
- R12: A beat completes only in a cycle where `bus_req` and `bus_ack` are both high. After an early-terminated transaction, `bus_req` is low for exactly one cycle before the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation from the settings |
| cfg_size | input | 4 | Beat size code (0100 word, else double word) |
| cfg_src_inc | input | 1 | 1 = step source address per beat |
| cfg_dst_inc | input | 1 | 1 = step destination address per beat |
| cfg_src | input | ADDR_W | Source start address |
| cfg_dst | input | ADDR_W | Destination start address |
| cfg_len | input | LEN_W | Byte count |
| bus_req | output | 1 | Transaction request |
| bus_rnw | output | 1 | 1 = read, 0 = write |
| bus_burst | output | 1 | Two or more beats of the chunk remain |
| bus_addr | output | ADDR_W | Address of the current beat |
| bus_be | output | 8 | Byte enables of the current beat |
| bus_wdata | output | 64 | Write data |
| bus_ack | input | 1 | Beat acknowledge |
| bus_term | input | 1 | With ack: this beat ends the transaction |
| bus_err | input | 1 | Slave error, aborts the operation |
| bus_rdata | input | 64 | Read data |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err_flag | output | 1 | Last operation ended on a bus error |
| cur_src | output | ADDR_W | Live source address |
| cur_dst | output | ADDR_W | Live destination address |
| cur_len | output | LEN_W | Live bytes still owed |

## Verification
The bench builds the engine with its defaults: 32-bit addresses, a 16-bit byte count and a 16-entry buffer. Chunk boundaries therefore appear at modest lengths. A 264-byte move crosses two full chunks and then a one-beat tail, and an 80-byte move fits in one chunk that early termination at three beats splits into four read transactions. The 16-bit count also allows odd tails and zero-length starts. The slave model returns read data that depends on both address and read order. This makes fixed-address reads distinguishable beat by beat.

// File: rtl/dma_pkg.sv
package dma_pkg;
  localparam int DATA_W = 64;
  localparam int BE_W   = DATA_W / 8;
  localparam logic [3:0] SIZE_WORD = 4'b0100;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PLAN, ST_RD, ST_RD_GAP, ST_WR, ST_WR_GAP
  } dma_state_t;

  // Any code other than the word code selects double-word beats.
  function automatic logic is_dword(input logic [3:0] code);
    return code != SIZE_WORD;
  endfunction

  function automatic logic [3:0] beat_bytes(input logic dw);
    return dw ? 4'd8 : 4'd4;
  endfunction

  // Beats needed to cover len bytes, rounding a partial beat up.
  function automatic logic [31:0] beats_needed(input logic [31:0] len, input logic dw);
    logic [32:0] s;
    s = {1'b0, len} + (dw ? 33'd7 : 33'd3);
    return 32'(s >> (dw ? 3 : 2));
  endfunction

  // Enable the lowest nbytes of the beat, steered to a 32-bit half in word mode.
  function automatic logic [BE_W-1:0] lane_be(input logic dw, input logic [3:0] nbytes,
                                               input logic a2);
    logic [BE_W-1:0] m;
    m = BE_W'((16'd1 << nbytes) - 16'd1);
    if (!dw) m = a2 ? {m[3:0], 4'h0} : {4'h0, m[3:0]};
    return m;
  endfunction
endpackage

// File: rtl/dma_buf.sv
module dma_buf #(
  parameter int DEPTH = 16,
  parameter int W     = 64,
  localparam int PW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [PW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [PW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/dma_lane.sv
module dma_lane #(
  parameter int W = 64,
  localparam int HALF = W / 2
) (
  input  logic         dw,
  input  logic         rd_a2,
  input  logic         wr_a2,
  input  logic [W-1:0] rdata,
  input  logic [W-1:0] buf_q,
  output logic [W-1:0] cap,
  output logic [W-1:0] wdata
);
  // Word mode keeps the addressed half in the low half of a buffer entry.
  assign cap = dw ? rdata
                  : {{HALF{1'b0}}, (rd_a2 ? rdata[W-1:HALF] : rdata[HALF-1:0])};

  assign wdata = dw ? buf_q
                    : (wr_a2 ? {buf_q[HALF-1:0], {HALF{1'b0}}}
                             : {{HALF{1'b0}}, buf_q[HALF-1:0]});
endmodule

// File: rtl/dma_mover.sv
module dma_mover
  import dma_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = 16,
  parameter int BUF_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [3:0]        cfg_size,
  input  logic              cfg_src_inc,
  input  logic              cfg_dst_inc,
  input  logic [ADDR_W-1:0] cfg_src,
  input  logic [ADDR_W-1:0] cfg_dst,
  input  logic [LEN_W-1:0]  cfg_len,
  output logic              bus_req,
  output logic              bus_rnw,
  output logic              bus_burst,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [BE_W-1:0]   bus_be,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_ack,
  input  logic              bus_term,
  input  logic              bus_err,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              busy,
  output logic              done,
  output logic              err_flag,
  output logic [ADDR_W-1:0] cur_src,
  output logic [ADDR_W-1:0] cur_dst,
  output logic [LEN_W-1:0]  cur_len
);
  localparam int PTR_W = $clog2(BUF_DEPTH);
  localparam int IDX_W = PTR_W + 1;

  dma_state_t        state;
  logic              dw_q, sinc_q, dinc_q, done_q, err_q;
  logic [ADDR_W-1:0] src_q, dst_q;
  logic [LEN_W-1:0]  len_q;
  logic [IDX_W-1:0]  chunk_q, rd_idx, wr_idx;

  // Named internal events, also watched by the checker.
  logic              in_rd, in_wr, beat_fire, abort_evt, txn_end;
  logic [IDX_W-1:0]  side_left, chunk_next;
  logic [3:0]        bb, tail;
  logic [31:0]       need;
  logic [LEN_W-1:0]  len_after;
  logic [DATA_W-1:0] cap_word, buf_q;

  assign bb        = beat_bytes(dw_q);
  assign in_rd     = (state == ST_RD);
  assign in_wr     = (state == ST_WR);
  assign bus_req   = in_rd | in_wr;
  assign bus_rnw   = in_rd;
  assign beat_fire = bus_req & bus_ack & ~bus_err;
  assign abort_evt = bus_req & bus_err;
  assign side_left = chunk_q - (in_rd ? rd_idx : wr_idx);
  assign txn_end   = beat_fire & (bus_term | (side_left == IDX_W'(1)));
  assign bus_burst = bus_req & (side_left >= IDX_W'(2));
  assign bus_addr  = in_wr ? dst_q : src_q;

  assign tail      = (len_q < LEN_W'(bb)) ? len_q[3:0] : bb;
  assign bus_be    = bus_req ? lane_be(dw_q, in_wr ? tail : bb, bus_addr[2]) : '0;
  assign len_after = (len_q > LEN_W'(bb)) ? len_q - LEN_W'(bb) : '0;

  assign need       = beats_needed(32'(len_q), dw_q);
  assign chunk_next = (need > 32'(BUF_DEPTH)) ? IDX_W'(BUF_DEPTH) : need[IDX_W-1:0];

  dma_buf #(.DEPTH(BUF_DEPTH), .W(DATA_W)) u_buf (
    .clk   (clk),
    .we    (in_rd & beat_fire),
    .waddr (rd_idx[PTR_W-1:0]),
    .wdata (cap_word),
    .raddr (wr_idx[PTR_W-1:0]),
    .rdata (buf_q)
  );

  dma_lane #(.W(DATA_W)) u_lane (
    .dw    (dw_q),
    .rd_a2 (src_q[2]),
    .wr_a2 (dst_q[2]),
    .rdata (bus_rdata),
    .buf_q (buf_q),
    .cap   (cap_word),
    .wdata (bus_wdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      dw_q    <= 1'b0;
      sinc_q  <= 1'b0;
      dinc_q  <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      src_q   <= '0;
      dst_q   <= '0;
      len_q   <= '0;
      chunk_q <= '0;
      rd_idx  <= '0;
      wr_idx  <= '0;
    end else begin
      done_q <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          dw_q   <= is_dword(cfg_size);
          sinc_q <= cfg_src_inc;
          dinc_q <= cfg_dst_inc;
          src_q  <= cfg_src;
          dst_q  <= cfg_dst;
          len_q  <= cfg_len;
          err_q  <= 1'b0;
          state  <= ST_PLAN;
        end
        ST_PLAN: if (len_q == '0) begin
          done_q <= 1'b1;
          state  <= ST_IDLE;
        end else begin
          chunk_q <= chunk_next;
          rd_idx  <= '0;
          wr_idx  <= '0;
          state   <= ST_RD;
        end
        ST_RD: if (abort_evt) begin
          err_q <= 1'b1;
          state <= ST_IDLE;
        end else if (beat_fire) begin
          rd_idx <= rd_idx + IDX_W'(1);
          if (sinc_q) src_q <= src_q + ADDR_W'(bb);
          if (txn_end) state <= ST_RD_GAP;
        end
        ST_RD_GAP: state <= (rd_idx == chunk_q) ? ST_WR : ST_RD;
        ST_WR: if (abort_evt) begin
          err_q <= 1'b1;
          state <= ST_IDLE;
        end else if (beat_fire) begin
          wr_idx <= wr_idx + IDX_W'(1);
          len_q  <= len_after;
          if (dinc_q) dst_q <= dst_q + ADDR_W'(bb);
          if (txn_end) state <= ST_WR_GAP;
        end
        ST_WR_GAP: state <= (wr_idx == chunk_q) ? ST_PLAN : ST_WR;
        default:   state <= ST_IDLE;
      endcase
    end
  end

  assign busy     = (state != ST_IDLE);
  assign done     = done_q;
  assign err_flag = err_q;
  assign cur_src  = src_q;
  assign cur_dst  = dst_q;
  assign cur_len  = len_q;
endmodule

// File: rtl/dma_mover_chk.sv
module dma_mover_chk #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16,
  parameter int IDX_W  = 5
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    busy,
  input logic                    done,
  input logic                    err_flag,
  input logic                    bus_req,
  input logic                    bus_rnw,
  input logic                    bus_burst,
  input logic [dma_pkg::BE_W-1:0] bus_be,
  input logic                    beat_fire,
  input logic                    abort_evt,
  input logic [ADDR_W-1:0]       cur_src,
  input logic [LEN_W-1:0]        cur_len,
  input logic                    src_inc,
  input logic                    dw,
  input logic [IDX_W-1:0]        rd_idx,
  input logic [IDX_W-1:0]        chunk
);
  assert_done_not_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_done_ends_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy));

  assert_write_after_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_rnw) |-> (rd_idx == chunk));

  assert_src_keyhole_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_fire && bus_rnw && !src_inc) |=> $stable(cur_src));

  assert_src_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_fire && bus_rnw && src_inc) |=> (cur_src == $past(cur_src) + ADDR_W'(dw ? 8 : 4)));

  assert_len_only_on_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !(beat_fire && !bus_rnw)) |=> $stable(cur_len));

  assert_abort_stops_R8: assert property (@(posedge clk) disable iff (!rst_n)
    abort_evt |=> (!busy && err_flag && !done));

  assert_be_present_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> (bus_be != '0));

  assert_single_beat_ends_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_fire && !bus_burst) |=> !bus_req);
endmodule

bind dma_mover dma_mover_chk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .IDX_W(IDX_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .done      (done),
  .err_flag  (err_flag),
  .bus_req   (bus_req),
  .bus_rnw   (bus_rnw),
  .bus_burst (bus_burst),
  .bus_be    (bus_be),
  .beat_fire (beat_fire),
  .abort_evt (abort_evt),
  .cur_src   (cur_src),
  .cur_len   (cur_len),
  .src_inc   (sinc_q),
  .dw        (dw_q),
  .rd_idx    (rd_idx),
  .chunk     (chunk_q)
);

// File: tb/dma_mover_tb.sv
module dma_mover_tb;
  import dma_pkg::*;

  localparam logic [3:0] SZ_W = 4'b0100;
  localparam logic [3:0] SZ_D = 4'b1000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  cfg_size = SZ_D;
  logic        cfg_src_inc = 1'b1, cfg_dst_inc = 1'b1;
  logic [31:0] cfg_src = '0, cfg_dst = '0;
  logic [15:0] cfg_len = '0;
  logic        bus_req, bus_rnw, bus_burst;
  logic [31:0] bus_addr;
  logic [7:0]  bus_be;
  logic [63:0] bus_wdata;
  logic        bus_ack = 1'b0, bus_term = 1'b0, bus_err = 1'b0;
  logic [63:0] bus_rdata = '0;
  logic        busy, done, err_flag;
  logic [31:0] cur_src, cur_dst;
  logic [15:0] cur_len;

  always #5 clk = ~clk;

  dma_mover u_dut (.*);

  typedef struct packed {
    logic [31:0] addr;
    logic [7:0]  be;
    logic [63:0] data;
  } wexp_t;

  wexp_t exp_q[$];
  int n_chk = 0, n_err = 0;

  // slave model settings and per-run records
  bit gap_mode = 0, toggle = 0, prev_req = 0, run_dw = 1;
  int term_after = 0, err_rd = -1, err_wr = -1;
  int rd_k = 0, rd_run = 0, wr_run = 0, tcnt = 0, low_run = 0, done_cnt = 0, txn_n = 0;
  bit txn_rnw [64];
  bit txn_burst [64];
  int txn_gap [64];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] rd_pat(input logic [31:0] a, input int k);
    return {a ^ 32'h5A000000 ^ (32'(k) << 20), ~a + 32'(k)};
  endfunction

  // slave and write monitor: everything happens at the falling edge
  always @(negedge clk) begin
    if (done) begin
      done_cnt++;
      chk(!busy, "R9", "busy during done", 64'(busy), 64'd0);
    end
    bus_ack = 1'b0; bus_term = 1'b0; bus_err = 1'b0;
    if (bus_req) begin
      if (!prev_req) begin
        if (txn_n < 64) begin
          txn_rnw[txn_n] = bus_rnw; txn_burst[txn_n] = bus_burst; txn_gap[txn_n] = low_run;
        end
        txn_n++;
        tcnt = 0;
      end
      low_run = 0;
      toggle = ~toggle;
      if (gap_mode && toggle) begin
        // stall this cycle
      end else if (bus_rnw && rd_run == err_rd) begin
        bus_err = 1'b1;
      end else if (!bus_rnw && wr_run == err_wr) begin
        bus_err = 1'b1;
      end else begin
        bus_ack = 1'b1;
        tcnt++;
        if (term_after > 0 && tcnt == term_after) bus_term = 1'b1;
        if (bus_rnw) begin
          logic [7:0] rbe;
          rbe = run_dw ? 8'hFF : (bus_addr[2] ? 8'hF0 : 8'h0F);
          chk(bus_be == rbe, "R6", "read byte enables", 64'(bus_be), 64'(rbe));
          bus_rdata = rd_pat(bus_addr, rd_k);
          rd_k++; rd_run++;
        end else begin
          wr_run++;
          if (exp_q.size() == 0) begin
            chk(1'b0, "R4", "unexpected write beat", 64'(bus_addr), 64'd0);
          end else begin
            wexp_t e;
            e = exp_q.pop_front();
            chk(bus_addr == e.addr, "R3", "write address", 64'(bus_addr), 64'(e.addr));
            chk(bus_be == e.be, "R6", "write byte enables", 64'(bus_be), 64'(e.be));
            chk(bus_wdata == e.data, "R11", "write data", bus_wdata, e.data);
          end
        end
      end
    end else begin
      low_run++;
    end
    prev_req = bus_req;
  end

  // driver: program, push the expected write beats, pulse start
  task automatic launch(input logic [31:0] s, input logic [31:0] d, input int len,
                        input logic [3:0] sz, input bit si, input bit di, input bit push);
    int bb, n, k0;
    bb = (sz == SZ_W) ? 4 : 8;
    n = (len + bb - 1) / bb;
    k0 = rd_k;
    run_dw = (sz != SZ_W);
    cfg_src = s; cfg_dst = d; cfg_len = 16'(len); cfg_size = sz;
    cfg_src_inc = si; cfg_dst_inc = di;
    rd_run = 0; wr_run = 0; txn_n = 0; done_cnt = 0;
    if (push) begin
      for (int i = 0; i < n; i++) begin
        logic [31:0] sa, da, w;
        logic [63:0] p, data;
        logic [7:0]  m, be;
        int nb;
        sa = s + (si ? 32'(i * bb) : 32'd0);
        da = d + (di ? 32'(i * bb) : 32'd0);
        p  = rd_pat(sa, k0 + i);
        nb = (len - i * bb < bb) ? len - i * bb : bb;
        m  = 8'((16'd1 << nb) - 16'd1);
        if (bb == 4) begin
          w    = sa[2] ? p[63:32] : p[31:0];
          data = da[2] ? {w, 32'h0} : {32'h0, w};
          be   = da[2] ? {m[3:0], 4'h0} : {4'h0, m[3:0]};
        end else begin
          data = p; be = m;
        end
        exp_q.push_back('{da, be, data});
      end
    end
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (busy);
    @(negedge clk);
  endtask

  task automatic finish_run(input string req, input logic [31:0] es, input logic [31:0] ed);
    chk(exp_q.size() == 0, "R4", "write beats left over", 64'(exp_q.size()), 64'd0);
    chk(done_cnt == 1, "R9", "done pulses", 64'(done_cnt), 64'd1);
    chk(cur_len == 16'd0, "R10", "final length", 64'(cur_len), 64'd0);
    chk(cur_src == es && cur_dst == ed, req, "final src/dst",
        {cur_src, cur_dst}, {es, ed});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !err_flag && !bus_req, "R9", "reset outputs",
        {busy, done, err_flag, bus_req}, 4'b0);

    // 264 bytes, double words: chunks of 16, 16, 1
    launch(32'h1000, 32'h4000, 264, SZ_D, 1, 1, 1);
    wait_idle();
    finish_run("R3", 32'h1108, 32'h4108);
    chk(txn_n == 6, "R4", "transaction count", 64'(txn_n), 64'd6);
    chk(txn_rnw[0] && !txn_rnw[1] && txn_rnw[2] && txn_rnw[4], "R4", "read/write order",
        {txn_rnw[0], txn_rnw[1], txn_rnw[2], txn_rnw[4]}, 4'b1011);
    chk(txn_burst[0] && txn_burst[2] && !txn_burst[4], "R5", "burst flags 16/16/1",
        {txn_burst[0], txn_burst[2], txn_burst[4]}, 3'b110);

    // words, source on upper half, destination on lower half
    launch(32'h104, 32'h200, 20, SZ_W, 1, 1, 1);
    wait_idle();
    finish_run("R2", 32'h118, 32'h214);

    // odd lengths: partial last beat
    launch(32'h300, 32'h500, 13, SZ_D, 1, 1, 1);
    wait_idle();
    finish_run("R6", 32'h310, 32'h510);
    launch(32'h300, 32'h204, 7, SZ_W, 1, 1, 1);
    wait_idle();
    finish_run("R11", 32'h308, 32'h20C);

    // fixed source, then fixed destination
    launch(32'h800, 32'h900, 40, SZ_D, 0, 1, 1);
    wait_idle();
    finish_run("R3", 32'h800, 32'h928);
    launch(32'hA00, 32'hB08, 24, SZ_W, 1, 0, 1);
    wait_idle();
    finish_run("R3", 32'hA18, 32'hB08);

    // early termination after three beats
    term_after = 3;
    launch(32'h1000, 32'h2000, 80, SZ_D, 1, 1, 1);
    wait_idle();
    term_after = 0;
    finish_run("R7", 32'h1050, 32'h2050);
    chk(txn_n == 8, "R7", "transactions after early ends", 64'(txn_n), 64'd8);
    chk(txn_rnw[3] && !txn_rnw[4], "R7", "resumed reads before writes",
        {txn_rnw[3], txn_rnw[4]}, 2'b10);
    chk(txn_gap[1] == 1, "R12", "request gap after early end", 64'(txn_gap[1]), 64'd1);

    // acknowledge only every other cycle
    gap_mode = 1;
    launch(32'h40, 32'h80, 40, SZ_W, 1, 1, 1);
    wait_idle();
    gap_mode = 0;
    finish_run("R12", 32'h68, 32'hA8);

    // start while busy is ignored
    launch(32'h1000, 32'h3000, 64, SZ_D, 1, 1, 1);
    repeat (3) @(negedge clk);
    cfg_src = 32'h7000; cfg_dst = 32'h7800; cfg_len = 16'd8;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_idle();
    finish_run("R1", 32'h1040, 32'h3040);
    repeat (3) @(negedge clk);
    chk(!busy, "R1", "no restart after ignored start", 64'(busy), 64'd0);

    // zero length
    launch(32'h100, 32'h200, 0, SZ_D, 1, 1, 1);
    wait_idle();
    chk(done_cnt == 1 && txn_n == 0, "R9", "zero length done/transactions",
        {32'(done_cnt), 32'(txn_n)}, {32'd1, 32'd0});

    // error on fourth read beat
    err_rd = 3;
    launch(32'h1000, 32'h2000, 64, SZ_D, 1, 1, 0);
    wait_idle();
    err_rd = -1;
    chk(err_flag && done_cnt == 0, "R8", "read error flag/done", {err_flag, 1'(done_cnt)}, 2'b10);
    chk(cur_src == 32'h1018 && cur_dst == 32'h2000 && cur_len == 16'd64, "R8",
        "partial after read error", {cur_src, cur_dst}, {32'h1018, 32'h2000});

    // error on third write beat
    err_wr = 2;
    launch(32'h1000, 32'h2000, 48, SZ_D, 1, 1, 1);
    wait_idle();
    err_wr = -1;
    chk(err_flag && done_cnt == 0, "R8", "write error flag/done", {err_flag, 1'(done_cnt)}, 2'b10);
    chk(cur_len == 16'd32, "R10", "length after write error", 64'(cur_len), 64'd32);
    chk(cur_src == 32'h1030 && cur_dst == 32'h2010, "R8", "addresses after write error",
        {cur_src, cur_dst}, {32'h1030, 32'h2010});
    chk(exp_q.size() == 4, "R8", "unwritten beats", 64'(exp_q.size()), 64'd4);
    exp_q.delete();

    // a fresh start clears the error
    launch(32'h600, 32'h700, 16, SZ_D, 1, 1, 1);
    wait_idle();
    chk(!err_flag, "R8", "error cleared by start", 64'(err_flag), 64'd0);
    finish_run("R3", 32'h610, 32'h710);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule